// File: doc/BRIEF.md
# Polled Console Register Block

This block sits on a simple synchronous load/store bus and gives a processor two character devices to drive by polling: a keyboard receiver and a display transmitter. Each device has a status word, whose bit 0 is a ready flag, and a data word. Software spins on the ready flag, then moves one byte through the data word. Hardware events alone move the ready flags, so the polling loop is the only handshake software needs.

On the keyboard side, an external strobe delivers bytes. Each one is latched and raises the keyboard ready flag. Reading the keyboard data word consumes the byte. A byte that arrives before the previous one was read replaces it, and the loss is recorded in a sticky flag.

On the display side, a write to the display data word takes the byte and drops display ready. The block then emits the byte on a one-cycle output strobe once the downstream device is not busy. Ready returns after the strobe, as soon as the downstream busy input is seen low.

Top module: `console_mmio`

## Requirements
- R1: After reset, keyboard status reads 0 (ready and overrun clear), display status reads 1 (ready) and the output strobe is low.
- R2: A read is a cycle with busSel=1 and busWe=0, and busRdata is valid in that same cycle. The registers sit at word addresses 0xFFFF0000 (keyboard status), 0xFFFF0004 (keyboard data), 0xFFFF0008 (display status) and 0xFFFF000C (display data). Display data reads back the last byte accepted, in bits 7:0.
- R3: A cycle with kbdValid=1 latches kbdByte. Keyboard status bit 0 reads 1 from the next cycle. Keyboard data returns the byte in bits 7:0, with the upper bits zero.
- R4: A read of keyboard data clears keyboard ready (bit 0) and overrun (bit 1) at the end of that cycle.
- R5: A byte that arrives while keyboard ready is 1 and is not being read in that cycle overwrites the held byte and sets overrun (keyboard status bit 1). Overrun stays set until the next keyboard data read.
- R6: When a keyboard data read and a new byte fall in the same cycle, the read returns the old byte. Afterwards ready is 1, overrun is 0 and the new byte is held.
- R7: Bus writes to either status register change no status bit.
- R8: A write (busSel=1, busWe=1) to display data while display ready is 1 captures busWdata[7:0], and display status bit 0 reads 0 from the next cycle.
- R9: After an accepted display write, dispStrobe pulses high for exactly one cycle. The pulse falls in the first cycle in which dispBusy is low, and dispByte carries the written byte during it.
- R10: After the strobe, display ready returns to 1 only after an edge at which dispBusy is low. While dispBusy stays high, ready stays 0.
- R11: A display data write while display ready is 0 is ignored. The held byte is unchanged and no extra strobe follows.
- R12: Reads of addresses that do not decode to one of the four words return zero, undefined status bits read zero, and writes to keyboard data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| kbdValid | input | 1 | Keyboard byte strobe |
| kbdByte | input | 8 | Keyboard byte |
| dispByte | output | 8 | Byte presented to the display |
| dispStrobe | output | 1 | One-cycle display output strobe |
| dispBusy | input | 1 | Display busy, holds off strobe and ready |

## Verification
The bench targets three corner cases.

- A keyboard byte that arrives in the same cycle as the data read. A design that orders the set and the clear wrongly would lose the new byte, or would report a false overrun.
- Repeated arrivals without a read. A design that drops the sticky overrun flag, or keeps the first byte, shows the wrong status or the wrong data.
- Busy held high on the display side, both before and after the strobe. A design that strobes into a busy device, strobes twice, raises ready too early, or accepts a second write while ready is low gives a wrong strobe count, a wrong byte or a wrong ready value.

Status writes and unmapped reads are also checked, to show that they leave the flags untouched and return zero.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } regSel_e;

  typedef enum logic [1:0] {
    DS_IDLE,
    DS_SEND,
    DS_DRAIN
  } dispState_e;

  typedef struct packed {
    regSel_e sel;
    logic    kbdTake;
    logic    dispLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/console_ctrl.sv
module console_ctrl
  import console_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              dispBusy,
  output ctrlStrobes_t      strobes,
  output logic              dispReady,
  output logic              dispStrobe
);
  localparam int WIN_LSB = 4;

  dispState_e state, stateNext;
  regSel_e    sel;
  logic       inWindow;

  assign inWindow = (busAddr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]) &&
                    (busAddr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (inWindow) begin
      case (busAddr[3:2])
        2'd0:    sel = SEL_KSTAT;
        2'd1:    sel = SEL_KDATA;
        2'd2:    sel = SEL_DSTAT;
        default: sel = SEL_DDATA;
      endcase
    end
  end

  assign dispReady = (state == DS_IDLE);
  assign dispStrobe = (state == DS_SEND) && !dispBusy;

  always_comb begin
    strobes.sel      = sel;
    strobes.kbdTake  = busSel && !busWe && (sel == SEL_KDATA);
    strobes.dispLoad = busSel && busWe && (sel == SEL_DDATA) && dispReady;
  end

  always_comb begin
    stateNext = state;
    case (state)
      DS_IDLE:  if (strobes.dispLoad) stateNext = DS_SEND;
      DS_SEND:  if (!dispBusy) stateNext = DS_DRAIN;
      DS_DRAIN: if (!dispBusy) stateNext = DS_IDLE;
      default:  stateNext = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= DS_IDLE;
    else       state <= stateNext;
  end

  // R9: the strobe lasts a single cycle and never meets a busy display
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dispStrobe |=> !dispStrobe);
  a_r9_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    dispStrobe |-> !dispBusy);
  // R8: an accepted display write drops ready
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dispLoad |=> !dispReady);
  // R10: ready never returns while busy was seen high
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!dispReady && dispBusy) |=> !dispReady);
endmodule

// File: rtl/console_dp.sv
module console_dp
  import console_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              dispReady,
  input  logic              kbdValid,
  input  logic [BYTE_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] dispByte
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] kbdData;
  logic              kbdReady;
  logic              kbdOverrun;
  logic [BYTE_W-1:0] dispData;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdData    <= '0;
      kbdReady   <= 1'b0;
      kbdOverrun <= 1'b0;
    end else if (kbdValid) begin
      kbdData    <= kbdByte;
      kbdReady   <= 1'b1;
      kbdOverrun <= strobes.kbdTake ? 1'b0 : (kbdOverrun | kbdReady);
    end else if (strobes.kbdTake) begin
      kbdReady   <= 1'b0;
      kbdOverrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dispData <= '0;
    else if (strobes.dispLoad) dispData <= busWdata[BYTE_W-1:0];
  end

  assign dispByte = dispData;

  always_comb begin
    busRdata = '0;
    case (strobes.sel)
      SEL_KSTAT: busRdata = {{(DATA_W-2){1'b0}}, kbdOverrun, kbdReady};
      SEL_KDATA: busRdata = {{PAD_W{1'b0}}, kbdData};
      SEL_DSTAT: busRdata = {{(DATA_W-1){1'b0}}, dispReady};
      SEL_DDATA: busRdata = {{PAD_W{1'b0}}, dispData};
      default:   busRdata = '0;
    endcase
  end

  // R4: a lone data read empties the keyboard slot
  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kbdTake && !kbdValid) |=> (!kbdReady && !kbdOverrun));
  // R5: arrival onto an unread byte flags overrun
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (kbdValid && kbdReady && !strobes.kbdTake) |=> kbdOverrun);
  // R6: a same-cycle read and arrival leaves a fresh byte and no overrun
  a_r6_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (kbdValid && strobes.kbdTake) |=> (kbdReady && !kbdOverrun));
  // R7: only keyboard events move the keyboard ready flag
  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!kbdValid && !strobes.kbdTake) |=> $stable(kbdReady));
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              kbdValid,
  input  logic [BYTE_W-1:0] kbdByte,
  output logic [BYTE_W-1:0] dispByte,
  output logic              dispStrobe,
  input  logic              dispBusy
);
  ctrlStrobes_t strobes;
  logic         dispReady;

  console_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .dispBusy(dispBusy), .strobes(strobes),
    .dispReady(dispReady), .dispStrobe(dispStrobe)
  );

  console_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dispReady(dispReady),
    .kbdValid(kbdValid), .kbdByte(kbdByte), .busWdata(busWdata),
    .busRdata(busRdata), .dispByte(dispByte)
  );
endmodule

// File: tb/test_console_mmio.sv
`timescale 1ns/1ps
module test_console_mmio;
  localparam logic [31:0] KSTAT = 32'hFFFF0000;
  localparam logic [31:0] KDATA = 32'hFFFF0004;
  localparam logic [31:0] DSTAT = 32'hFFFF0008;
  localparam logic [31:0] DDATA = 32'hFFFF000C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] busRdata;
  logic        kbdValid = 1'b0;
  logic [7:0]  kbdByte = '0;
  logic [7:0]  dispByte;
  logic        dispStrobe;
  logic        dispBusy = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  int strobeCnt = 0;
  logic [7:0] lastByte = '0;

  always #2.5 clk = ~clk;

  console_mmio i_console_mmio (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .kbdValid(kbdValid), .kbdByte(kbdByte), .dispByte(dispByte),
    .dispStrobe(dispStrobe), .dispBusy(dispBusy)
  );

  always @(posedge clk) begin
    if (rstN && dispStrobe) begin
      strobeCnt = strobeCnt + 1;
      lastByte = dispByte;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [31:0] addr, output logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = addr;
    #1 data = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic busWrite(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk);
    #1 busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic kbdPush(input logic [7:0] b);
    @(negedge clk);
    kbdValid = 1'b1; kbdByte = b;
    @(posedge clk);
    #1 kbdValid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1 chk("R1 strobe", {31'b0, dispStrobe}, 32'h0);
    busRead(KSTAT, d); chk("R1 kbd status", d, 32'h0);
    busRead(DSTAT, d); chk("R1 disp status", d, 32'h1);
    busRead(DDATA, d); chk("R2 disp data init", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    busRead(32'hFFFF0010, d); chk("R12 above window", d, 32'h0);
    busRead(32'h00000004, d); chk("R12 low address", d, 32'h0);
    busRead(32'hFFFF0002, d); chk("R12 unaligned", d, 32'h0);
  endtask

  task automatic t_kbdBasic;
    logic [31:0] d;
    kbdPush(8'h41);
    busRead(KSTAT, d); chk("R3 ready set", d, 32'h1);
    busRead(KDATA, d); chk("R3 data", d, 32'h41);
    busRead(KSTAT, d); chk("R4 ready cleared", d, 32'h0);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    kbdPush(8'h11);
    kbdPush(8'h22);
    busRead(KSTAT, d); chk("R5 overrun", d, 32'h3);
    kbdPush(8'h33);
    busRead(KSTAT, d); chk("R5 sticky", d, 32'h3);
    busRead(KDATA, d); chk("R5 newest byte", d, 32'h33);
    busRead(KSTAT, d); chk("R4 overrun cleared", d, 32'h0);
  endtask

  task automatic t_sameCycle;
    logic [31:0] d;
    kbdPush(8'h55);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = KDATA;
    kbdValid = 1'b1; kbdByte = 8'h66;
    #1 chk("R6 old byte returned", busRdata, 32'h55);
    @(posedge clk);
    #1 busSel = 1'b0; kbdValid = 1'b0;
    busRead(KSTAT, d); chk("R6 ready, no overrun", d, 32'h1);
    busRead(KDATA, d); chk("R6 new byte", d, 32'h66);
  endtask

  task automatic t_statusWrites;
    logic [31:0] d;
    kbdPush(8'h77);
    busWrite(KSTAT, 32'h0);
    busRead(KSTAT, d); chk("R7 kbd ready kept", d, 32'h1);
    busWrite(KDATA, 32'hFF);
    busRead(KDATA, d); chk("R12 kbd data write ignored", d, 32'h77);
    busWrite(DSTAT, 32'h0);
    busRead(DSTAT, d); chk("R7 disp ready kept", d, 32'h1);
    busWrite(KSTAT, 32'hFFFFFFFF);
    busRead(KSTAT, d); chk("R7 kbd status after write", d, 32'h0);
  endtask

  task automatic t_dispBusy;
    logic [31:0] d;
    int base;
    base = strobeCnt;
    @(negedge clk) dispBusy = 1'b1;
    busWrite(DDATA, 32'hDEADBEA5);
    busRead(DSTAT, d); chk("R8 ready dropped", d, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 held while busy", strobeCnt, base);
    dispBusy = 1'b0;
    @(posedge clk);
    #1 dispBusy = 1'b1;
    chk("R9 one strobe", strobeCnt, base + 1);
    chk("R9 strobe byte", {24'b0, lastByte}, 32'hA5);
    repeat (3) @(negedge clk);
    busRead(DSTAT, d); chk("R10 not ready while busy", d, 32'h0);
    @(negedge clk) dispBusy = 1'b0;
    @(posedge clk);
    busRead(DSTAT, d); chk("R10 ready back", d, 32'h1);
    chk("R9 still one strobe", strobeCnt, base + 1);
    busRead(DDATA, d); chk("R2 disp data", d, 32'hA5);
  endtask

  task automatic t_dispFree;
    logic [31:0] d;
    int base;
    base = strobeCnt;
    busWrite(DDATA, 32'h3C);
    busRead(DSTAT, d); chk("R8 ready low after write", d, 32'h0);
    repeat (4) @(negedge clk);
    chk("R9 free strobe", strobeCnt, base + 1);
    chk("R9 free byte", {24'b0, lastByte}, 32'h3C);
    busRead(DSTAT, d); chk("R10 ready free", d, 32'h1);
  endtask

  task automatic t_dispIgnore;
    logic [31:0] d;
    int base;
    base = strobeCnt;
    @(negedge clk) dispBusy = 1'b1;
    busWrite(DDATA, 32'h10);
    busWrite(DDATA, 32'h20);
    busRead(DDATA, d); chk("R11 byte kept", d, 32'h10);
    @(negedge clk) dispBusy = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 single strobe", strobeCnt, base + 1);
    chk("R11 strobe byte", {24'b0, lastByte}, 32'h10);
    busRead(DSTAT, d); chk("R11 ready", d, 32'h1);
    repeat (4) @(negedge clk);
    chk("R11 no late strobe", strobeCnt, base + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_unmapped();
    t_kbdBasic();
    t_overrun();
    t_sameCycle();
    t_statusWrites();
    t_dispBusy();
    t_dispFree();
    t_dispIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #50000;
    vectors++;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule